// File: doc/BRIEF.md
# Byte-Wide General-Purpose I/O Port

This block is one general-purpose I/O port of a small microcontroller. A simple register bus reaches three byte registers. The direction register sets which pins drive. The output latch holds the values that driven pins carry. The input register reads back the state of each pin. The bus carries an address, write data, a write strobe and a per-bit write mask, and it reads combinationally. A full byte store uses an all-ones mask. A single-bit set or clear operation uses a mask with only its target bit set.

A write to the input register does not load it. It toggles each output-latch bit whose data bit and mask bit are both one. Because the mask qualifies the toggle, a single-bit set on the input register flips exactly one pin. The rest of the byte that the operation read back and wrote again has no effect.

Every write to the output latch or the input register raises a one-cycle notification. The notification carries the new latch value and the value it replaced. External pins pass through a two-flop synchronizer and then a sampling register before software can read them.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction register, output latch and input register all read 0x00, pin_oe and pin_out are 0x00, and chg_valid is low.
- R2: The registers sit at byte addresses 0x29 (input), 0x2A (direction) and 0x2B (output latch). Any other address reads 0x00, and a write to it changes no register and raises no notification.
- R3: A write to the direction register or the output latch replaces only the bits whose mask bit is 1. Bits with mask bit 0 keep their value. Mask 0xFF replaces the whole byte.
- R4: A write to the input register sets the output latch to latch XOR (wdata AND mask). It never loads the input register with wdata.
- R5: With direction 0x48 and latch 0x48, an input-register write of data 0x48 with mask 0x40 leaves the latch at 0x08.
- R6: chg_valid is high for exactly the one cycle after each output-latch or input-register write. During that cycle chg_new holds the new latch value and chg_old holds the previous one. chg_valid is low in every other cycle.
- R7: pin_oe always equals the direction register, and pin_out always equals the output latch.
- R8: One clock after the latch or direction settles, each bit whose direction bit is 1 reads back from the input register as the latch value.
- R9: Each bit whose direction bit is 0 reads the external pin. A change at pin_in shows in the input register after the third rising edge, counted from the first edge at which pin_in holds the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_wmask | input | 8 | Per-bit write qualifier |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for bus_addr |
| pin_in | input | 8 | External pin levels (asynchronous) |
| pin_out | output | 8 | Driven pin values |
| pin_oe | output | 8 | Per-pin output enable |
| chg_valid | output | 1 | Latch-update notification pulse |
| chg_new | output | 8 | Latch value after the update |
| chg_old | output | 8 | Latch value before the update |

## Verification
The hardest case to reach from the ports is a toggle where the mask and the data disagree. This is the case where a read-back byte carries extra ones that the mask must discard. The bench sweeps all 256 mask values against data patterns that set bits outside the mask, and predicts the latch arithmetically after each toggle. It also holds a pin value steady and then changes it. It reads the input register after two and after three edges, which checks the synchronizer latency exactly.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_IN   = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_OUT  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int unsigned LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], async_in[b]};
        end
        assign sync_out[b] = chain[LAST];
    end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_sel_e         sel,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] wmask,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] out_q,
    output logic             chg_valid,
    output logic [WIDTH-1:0] chg_new,
    output logic [WIDTH-1:0] chg_old
);

    logic [WIDTH-1:0] dir_d, out_d, merged;
    logic             touch_out;

    assign merged = (wdata & wmask);

    always_comb begin
        dir_d     = dir_q;
        out_d     = out_q;
        touch_out = 1'b0;
        if (we) begin
            unique case (sel)
                SEL_DIR: dir_d = (dir_q & ~wmask) | merged;
                SEL_OUT: begin
                    out_d     = (out_q & ~wmask) | merged;
                    touch_out = 1'b1;
                end
                SEL_IN: begin
                    out_d     = out_q ^ merged;
                    touch_out = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q     <= '0;
            out_q     <= '0;
            chg_valid <= 1'b0;
            chg_new   <= '0;
            chg_old   <= '0;
        end else begin
            dir_q     <= dir_d;
            out_q     <= out_d;
            chg_valid <= touch_out;
            if (touch_out) begin
                chg_new <= out_d;
                chg_old <= out_q;
            end
        end
    end

    AST_TOGGLE_MASK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_IN) |=> (((out_q ^ $past(out_q)) & ~$past(wmask)) == '0)); // R4

    AST_MASKED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_OUT) |=> (((out_q ^ $past(out_q)) & ~$past(wmask)) == '0)); // R3

    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel == SEL_DIR) |=> $stable(dir_q)); // R3

    AST_NOTIFY_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && (sel == SEL_OUT || sel == SEL_IN)) |=> !chg_valid); // R6

    AST_NOTIFY_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
        chg_valid |-> (chg_new == out_q && chg_old == $past(out_q))); // R6

endmodule

// File: rtl/gpio_port_sense.sv
module gpio_port_sense #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] out_q,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] in_q
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)      in_q[b] <= 1'b0;
            else if (dir_q[b]) in_q[b] <= out_q[b];
            else             in_q[b] <= pin_sync[b];
        end
    end

    AST_OUTPUT_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((in_q ^ $past(out_q)) & $past(dir_q)) == '0)); // R8

    AST_INPUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((in_q ^ $past(pin_sync)) & ~$past(dir_q)) == '0)); // R9

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH    = 8,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned IN_ADDR  = 'h29,
    parameter int unsigned DIR_ADDR = 'h2A,
    parameter int unsigned OUT_ADDR = 'h2B,
    parameter int unsigned SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic [WIDTH-1:0]  bus_wmask,
    input  logic              bus_we,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic              chg_valid,
    output logic [WIDTH-1:0]  chg_new,
    output logic [WIDTH-1:0]  chg_old
);

    localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(IN_ADDR);
    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(DIR_ADDR);
    localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(OUT_ADDR);

    reg_sel_e         sel;
    logic [WIDTH-1:0] dir_q, out_q, in_q, pin_sync;

    always_comb begin
        if      (bus_addr == A_IN)  sel = SEL_IN;
        else if (bus_addr == A_DIR) sel = SEL_DIR;
        else if (bus_addr == A_OUT) sel = SEL_OUT;
        else                        sel = SEL_NONE;
    end

    gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
    );

    gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(sel), .we(bus_we),
        .wdata(bus_wdata), .wmask(bus_wmask),
        .dir_q(dir_q), .out_q(out_q),
        .chg_valid(chg_valid), .chg_new(chg_new), .chg_old(chg_old)
    );

    gpio_port_sense #(.WIDTH(WIDTH)) u_sense (
        .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .out_q(out_q),
        .pin_sync(pin_sync), .in_q(in_q)
    );

    always_comb begin
        unique case (sel)
            SEL_IN:  bus_rdata = in_q;
            SEL_DIR: bus_rdata = dir_q;
            SEL_OUT: bus_rdata = out_q;
            default: bus_rdata = '0;
        endcase
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;

    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_NONE) |=> ($stable(pin_out) && $stable(pin_oe) && !chg_valid)); // R2

endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;

    localparam logic [7:0] A_IN  = 8'h29;
    localparam logic [7:0] A_DIR = 8'h2A;
    localparam logic [7:0] A_OUT = 8'h2B;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0, bus_wmask = '0, pin_in = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata, pin_out, pin_oe, chg_new, chg_old;
    logic       chg_valid;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] m_dir = '0, m_out = '0;

    always #5 clk = ~clk;

    gpio_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wmask(bus_wmask), .bus_we(bus_we), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .chg_valid(chg_valid), .chg_new(chg_new), .chg_old(chg_old)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // write spans one rising edge; returns at the next falling edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic [7:0] m);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wmask = m; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_DIR, v); chk("R1 dir", v, 8'h00);
        rd(A_OUT, v); chk("R1 out", v, 8'h00);
        rd(A_IN,  v); chk("R1 in",  v, 8'h00);
        chk("R1 oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 chg_valid", chg_valid, 1'b0);

        // R5 worked example, with R6 notifications
        wr(A_DIR, 8'h48, 8'hFF);
        chk("R6 no pulse on dir write", chg_valid, 1'b0);
        wr(A_OUT, 8'h48, 8'hFF);
        chk("R6 pulse", chg_valid, 1'b1);
        chk("R6 new", chg_new, 8'h48);
        chk("R6 old", chg_old, 8'h00);
        wr(A_IN, 8'h48, 8'h40);
        chk("R5 latch", pin_out, 8'h08);
        chk("R6 pulse2", chg_valid, 1'b1);
        chk("R6 new2", chg_new, 8'h08);
        chk("R6 old2", chg_old, 8'h48);
        @(negedge clk);
        chk("R6 single cycle", chg_valid, 1'b0);
        m_dir = 8'h48; m_out = 8'h08;

        // R4 sweep of every mask with data carrying bits outside it
        for (int m = 0; m < 256; m++) begin
            logic [7:0] d, prev;
            d = 8'(m * 37) ^ 8'hA5;
            prev = m_out;
            m_out = m_out ^ (d & 8'(m));
            wr(A_IN, d, 8'(m));
            chk("R4 toggle", pin_out, m_out);
            chk("R6 old sweep", chg_old, prev);
        end

        // R3 masked loads, R7 pin mirroring
        for (int k = 0; k < 64; k++) begin
            logic [7:0] d, m;
            d = 8'(k * 53 + 7);
            m = 8'(k * 29) ^ 8'h3C;
            m_dir = (m_dir & ~m) | (d & m);
            wr(A_DIR, d, m);
            rd(A_DIR, v); chk("R3 dir", v, m_dir);
            chk("R7 oe", pin_oe, m_dir);
            m_out = (m_out & ~m) | (~d & m);
            wr(A_OUT, ~d, m);
            rd(A_OUT, v); chk("R3 out", v, m_out);
            chk("R7 pin_out", pin_out, m_out);
        end

        // R8/R9 mixed readback with steady pins
        pin_in = 8'h96;
        for (int k = 0; k < 8; k++) begin
            wr(A_DIR, 8'(k * 45 + 3), 8'hFF);
            m_dir = 8'(k * 45 + 3);
            @(negedge clk);
            rd(A_IN, v);
            chk("R8 readback", v & m_dir, m_out & m_dir);
            chk("R9 input", v & ~m_dir, pin_in & ~m_dir);
        end

        // R9 latency
        wr(A_DIR, 8'h00, 8'hFF); m_dir = 8'h00;
        repeat (4) @(negedge clk);
        pin_in = 8'h5A;
        repeat (2) @(negedge clk);
        rd(A_IN, v); chk("R9 not yet", v, 8'h96);
        @(negedge clk);
        rd(A_IN, v); chk("R9 arrived", v, 8'h5A);

        // R2 unmapped addresses
        wr(A_DIR, 8'hF0, 8'hFF); m_dir = 8'hF0;
        wr(8'h28, 8'hFF, 8'hFF);
        chk("R2 no pulse", chg_valid, 1'b0);
        wr(8'h2C, 8'h0F, 8'hFF);
        rd(8'h2C, v); chk("R2 unmapped read", v, 8'h00);
        rd(A_DIR, v); chk("R2 dir kept", v, m_dir);
        rd(A_OUT, v); chk("R2 out kept", v, m_out);
        // R4 input register not loaded: bits with dir=0 still show pins
        wr(A_IN, 8'h00, 8'hFF);
        @(negedge clk);
        rd(A_IN, v); chk("R4 in not loaded", v, (m_out & m_dir) | (pin_in & ~m_dir));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule